// File: doc/BRIEF.md
# TLB Maintenance Register File

This block gives a processor three control registers through which software reads and writes the entries of a set-associative translation buffer. It also owns the tag and data array those registers reach. The three registers are an access word, a control word and a page-table word. The access word holds the permission flags and the physical frame number. The control word holds the read trigger, the write enable, the process identifier and the way select. The page-table word holds the table base and the virtual page number. Software writes one register per cycle on a single write port, and all three read-back values appear on output ports.

Writes have side effects. An access-word write, while the control word's write enable is set, stores an entry into the array and steps the way select. A control-word write with its read trigger set copies the selected entry back into all three read-back registers. A change of process identifier raises a one-cycle flush pulse that names the previous identifier. Replacing a valid entry with different contents raises a one-cycle page-flush pulse that carries the old page address.

Each register keeps the value software last wrote apart from the value it reads back. The virtual page number used to index the array is the last one written, even when a read has since changed the visible page number. Every effect of a write is visible on the outputs after the clock edge that samples it.

Top module: `tlb_maint_regs`

## Requirements
- R1: Synchronous active-high reset clears all three read-back registers, both flush pulses, the latched page number, the latched identifier and every array entry, so that a read of any entry after reset returns zero fields.
- R2: An access-word write (`wr_sel`=0) while control bit 1 (write enable) is set stores an entry. The entry index is way × ENTRIES_PER_WAY + (latched page number mod ENTRIES_PER_WAY). The way comes from control bits [24 +: log2 WAYS]. The latched page number is bits [21:2] of the last page-table write.
- R3: The stored tag holds the page number, the global flag (access bit 24), a valid bit and the latched identifier. The valid bit is set only when the page number is below 0xC0000. Overwriting an invalid entry never raises a page flush.
- R4: The stored data keeps access bits [23:0] only: the cacheable, read, write and execute flags at bits 23 to 20 and the frame number at [19:0]. The global flag lives in the tag and returns at access bit 24 on a read.
- R5: After every stored entry, whether its contents changed or not, the control word's way field increments and wraps modulo WAYS.
- R6: A control-word write (`wr_sel`=1) with bit 0 (read trigger) set loads three registers from the entry at the way in the written value's way field. The access read-back takes the data and global flag and keeps its bits [31:25]. The control read-back takes the written value with the identifier field [4 +: PIDW] replaced by the tag's identifier. The page-table read-back takes the tag's page number in bits [21:2].
- R7: A page-table write (`wr_sel`=2) replaces only bits [31:22] and [1:0] of the page-table read-back. Its bits [21:2] are latched separately for indexing.
- R8: An access-word write never changes the access read-back value.
- R9: A control-word write whose identifier field differs from the last written one raises `flush_pid_vld` for one cycle, with `flush_pid` equal to the previous identifier.
- R10: When a store changes the tag or data of a valid entry, `flush_page_vld` pulses for one cycle with `flush_page_addr` = old page number × 4096. A store that leaves both tag and data unchanged raises no flush.
- R11: With write enable clear, an access-word write stores nothing. A write with `wr_sel`=3, or a cycle with `wr_en` low, changes no register and raises no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target register: 0 access, 1 control, 2 page-table, 3 none |
| wr_data | input | 32 | Value written |
| acc_q | output | 32 | Access word read-back |
| misc_q | output | 32 | Control word read-back |
| pta_q | output | 32 | Page-table word read-back |
| flush_page_vld | output | 1 | One-cycle page flush pulse |
| flush_page_addr | output | 32 | Page address of the replaced entry |
| flush_pid_vld | output | 1 | One-cycle identifier flush pulse |
| flush_pid | output | PIDW | Previous process identifier to flush |

## Verification
A single control-word write can both change the process identifier and trigger an entry read. The identifier flush then fires in the same cycle that the three read-back registers reload. The bench provokes this by writing a new identifier together with the read trigger. It judges each effect separately: the flush must name the previously written identifier, while the control read-back must carry the tag's identifier rather than the written one. A store can also raise a page flush in the same cycle that the way select wraps from the last way to way 0. The bench steps the way through all four ways and then rewrites an occupied entry, and checks the flush address and the wrapped way field against its reference model on every clock.

// File: rtl/tlb_maint_pkg.sv
package tlb_maint_pkg;
    localparam int VPNW      = 20;
    localparam int PFNW      = 20;
    localparam int DATAW     = 24;
    localparam int PAGE_BITS = 12;
    localparam int CTL_RD    = 0;
    localparam int CTL_WE    = 1;
    localparam int PID_LSB   = 4;
    localparam int WAY_LSB   = 24;
    localparam int ACC_G     = 24;
    localparam int VPN_LSB   = 2;

    typedef enum logic [1:0] {
        SEL_ACC  = 2'd0,
        SEL_MISC = 2'd1,
        SEL_PTA  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_ACC_PLAIN,
        OP_COMMIT,
        OP_MISC_PLAIN,
        OP_MISC_READ,
        OP_PTA
    } op_e;
endpackage

// File: rtl/tlb_maint_index.sv
module tlb_maint_index #(
    parameter int WAYS            = 4,
    parameter int ENTRIES_PER_WAY = 8,
    localparam int WAYW  = $clog2(WAYS),
    localparam int EPWW  = $clog2(ENTRIES_PER_WAY),
    localparam int IDXW  = $clog2(WAYS * ENTRIES_PER_WAY)
) (
    input  logic [WAYW-1:0] way,
    input  logic [EPWW-1:0] vpn_lo,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        idx = IDXW'(way) * IDXW'(ENTRIES_PER_WAY) + IDXW'(vpn_lo);
    end
endmodule

// File: rtl/tlb_maint_build.sv
module tlb_maint_build
    import tlb_maint_pkg::*;
#(
    parameter int PIDW        = 8,
    parameter int VALID_LIMIT = 'hC0000,
    localparam int TAGW = VPNW + 2 + PIDW
) (
    input  logic [VPNW-1:0]  vpn,
    input  logic [PIDW-1:0]  pid,
    input  logic [ACC_G:0]   acc_word,
    output logic [TAGW-1:0]  tag,
    output logic [DATAW-1:0] data
);
    logic valid;

    always_comb begin
        valid = ({12'd0, vpn} < 32'(VALID_LIMIT));
        tag   = {vpn, acc_word[ACC_G], valid, pid};
        data  = acc_word[DATAW-1:0];
    end
endmodule

// File: rtl/tlb_maint_array.sv
module tlb_maint_array #(
    parameter int ENTRIES = 32,
    parameter int TAGW    = 30,
    parameter int DATAW   = 24,
    localparam int IDXW   = $clog2(ENTRIES),
    localparam int EW     = TAGW + DATAW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDXW-1:0]  idx,
    input  logic [TAGW-1:0]  wr_tag,
    input  logic [DATAW-1:0] wr_data,
    output logic [TAGW-1:0]  rd_tag,
    output logic [DATAW-1:0] rd_data
);
    logic [EW-1:0] mem [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[e] <= '0;
            end else if (we && (idx == IDXW'(e))) begin
                mem[e] <= {wr_tag, wr_data};
            end
        end
    end

    always_comb begin
        {rd_tag, rd_data} = mem[idx];
    end
endmodule

// File: rtl/tlb_maint_regs.sv
module tlb_maint_regs
    import tlb_maint_pkg::*;
#(
    parameter int WAYS            = 4,
    parameter int ENTRIES_PER_WAY = 8,
    parameter int PIDW            = 8,
    parameter int VALID_LIMIT     = 'hC0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [31:0]     wr_data,
    output logic [31:0]     acc_q,
    output logic [31:0]     misc_q,
    output logic [31:0]     pta_q,
    output logic            flush_page_vld,
    output logic [31:0]     flush_page_addr,
    output logic            flush_pid_vld,
    output logic [PIDW-1:0] flush_pid
);
    localparam int WAYW    = $clog2(WAYS);
    localparam int EPWW    = $clog2(ENTRIES_PER_WAY);
    localparam int ENTRIES = WAYS * ENTRIES_PER_WAY;
    localparam int IDXW    = $clog2(ENTRIES);
    localparam int TAGW    = VPNW + 2 + PIDW;

    op_e              op;
    logic [VPNW-1:0]  vpn_wr;
    logic [PIDW-1:0]  pid_wr;
    logic [WAYW-1:0]  way_sel;
    logic [IDXW-1:0]  idx;
    logic [TAGW-1:0]  new_tag, old_tag;
    logic [DATAW-1:0] new_data, old_data;
    logic             changed;
    logic             arr_we;
    logic             old_valid, old_g;
    logic [VPNW-1:0]  old_vpn;
    logic [PIDW-1:0]  old_pid;
    logic [PIDW-1:0]  wr_pid;
    logic [31:0]      misc_loaded;

    // decode the write into one operation
    always_comb begin
        op = OP_IDLE;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_ACC:  op = misc_q[CTL_WE] ? OP_COMMIT : OP_ACC_PLAIN;
                SEL_MISC: op = wr_data[CTL_RD] ? OP_MISC_READ : OP_MISC_PLAIN;
                SEL_PTA:  op = OP_PTA;
                SEL_NONE: op = OP_IDLE;
            endcase
        end
    end

    always_comb begin
        way_sel = (op == OP_MISC_READ) ? wr_data[WAY_LSB +: WAYW]
                                       : misc_q[WAY_LSB +: WAYW];
        wr_pid  = wr_data[PID_LSB +: PIDW];
    end

    tlb_maint_index #(
        .WAYS(WAYS), .ENTRIES_PER_WAY(ENTRIES_PER_WAY)
    ) u_index (
        .way(way_sel), .vpn_lo(vpn_wr[EPWW-1:0]), .idx(idx)
    );

    tlb_maint_build #(
        .PIDW(PIDW), .VALID_LIMIT(VALID_LIMIT)
    ) u_build (
        .vpn(vpn_wr), .pid(pid_wr), .acc_word(wr_data[ACC_G:0]),
        .tag(new_tag), .data(new_data)
    );

    tlb_maint_array #(
        .ENTRIES(ENTRIES), .TAGW(TAGW), .DATAW(DATAW)
    ) u_array (
        .clk(clk), .rst(rst), .we(arr_we), .idx(idx),
        .wr_tag(new_tag), .wr_data(new_data),
        .rd_tag(old_tag), .rd_data(old_data)
    );

    always_comb begin
        old_pid   = old_tag[PIDW-1:0];
        old_valid = old_tag[PIDW];
        old_g     = old_tag[PIDW+1];
        old_vpn   = old_tag[TAGW-1 -: VPNW];
        changed   = (old_tag != new_tag) || (old_data != new_data);
        arr_we    = (op == OP_COMMIT) && changed;
        misc_loaded = wr_data;
        misc_loaded[PID_LSB +: PIDW] = old_pid;
    end

    // register and pulse updates
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q           <= '0;
            misc_q          <= '0;
            pta_q           <= '0;
            vpn_wr          <= '0;
            pid_wr          <= '0;
            flush_page_vld  <= 1'b0;
            flush_page_addr <= '0;
            flush_pid_vld   <= 1'b0;
            flush_pid       <= '0;
        end else begin
            flush_page_vld <= 1'b0;
            flush_pid_vld  <= 1'b0;
            unique case (op)
                OP_IDLE, OP_ACC_PLAIN: begin
                end
                OP_COMMIT: begin
                    if (changed && old_valid) begin
                        flush_page_vld  <= 1'b1;
                        flush_page_addr <= {old_vpn, {PAGE_BITS{1'b0}}};
                    end
                    misc_q[WAY_LSB +: WAYW] <= way_sel + 1'b1;
                end
                OP_MISC_PLAIN, OP_MISC_READ: begin
                    if (wr_pid != pid_wr) begin
                        flush_pid_vld <= 1'b1;
                        flush_pid     <= pid_wr;
                    end
                    pid_wr <= wr_pid;
                    if (op == OP_MISC_READ) begin
                        misc_q <= misc_loaded;
                        acc_q  <= {acc_q[31:ACC_G+1], old_g, old_data};
                        pta_q[VPN_LSB +: VPNW] <= old_vpn;
                    end else begin
                        misc_q <= wr_data;
                    end
                end
                OP_PTA: begin
                    pta_q[31:VPN_LSB+VPNW] <= wr_data[31:VPN_LSB+VPNW];
                    pta_q[VPN_LSB-1:0]     <= wr_data[VPN_LSB-1:0];
                    vpn_wr                 <= wr_data[VPN_LSB +: VPNW];
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/tlb_maint_regs_chk.sv
module tlb_maint_regs_chk
    import tlb_maint_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int PIDW = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [1:0]      wr_sel,
    input logic [31:0]     acc_q,
    input logic [31:0]     misc_q,
    input logic [31:0]     pta_q,
    input logic            flush_page_vld,
    input logic            flush_pid_vld
);
    localparam int WAYW = $clog2(WAYS);

    AST_WAY_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_ACC && misc_q[CTL_WE]) |=>
        (misc_q[WAY_LSB +: WAYW] == WAYW'($past(misc_q[WAY_LSB +: WAYW]) + 1'b1))); // R5

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_ACC) |=> $stable(acc_q)); // R8

    AST_PTA_VPN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_PTA) |=> $stable(pta_q[VPN_LSB +: VPNW])); // R7

    AST_PAGE_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (rst)
        flush_page_vld |-> $past(wr_en && wr_sel == SEL_ACC && misc_q[CTL_WE])); // R10

    AST_PID_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (rst)
        flush_pid_vld |-> $past(wr_en && wr_sel == SEL_MISC)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || wr_sel == SEL_NONE) |=>
        (!flush_page_vld && !flush_pid_vld && $stable(acc_q) &&
         $stable(misc_q) && $stable(pta_q))); // R11
endmodule

bind tlb_maint_regs tlb_maint_regs_chk #(.WAYS(WAYS), .PIDW(PIDW)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .acc_q(acc_q), .misc_q(misc_q), .pta_q(pta_q),
    .flush_page_vld(flush_page_vld), .flush_pid_vld(flush_pid_vld)
);

// File: tb/tlb_maint_regs_test.sv
module tlb_maint_regs_test;
    localparam int WAYS = 4;
    localparam int EPW  = 8;
    localparam int PIDW = 8;
    localparam int N    = WAYS * EPW;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_sel = 2'd3;
    logic [31:0]     wr_data = '0;
    logic [31:0]     acc_q, misc_q, pta_q, flush_page_addr;
    logic            flush_page_vld, flush_pid_vld;
    logic [PIDW-1:0] flush_pid;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [19:0] m_vpn [N];
    logic        m_g   [N];
    logic        m_v   [N];
    logic [7:0]  m_pid [N];
    logic [23:0] m_dat [N];
    logic [31:0] e_acc, e_misc, e_pta, e_fpa;
    logic        e_fpv, e_fidv;
    logic [7:0]  e_fid;
    logic [19:0] vpn_sh;
    logic [7:0]  pid_sh;

    always #4 clk = ~clk;

    tlb_maint_regs #(.WAYS(WAYS), .ENTRIES_PER_WAY(EPW), .PIDW(PIDW)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .acc_q(acc_q), .misc_q(misc_q), .pta_q(pta_q),
        .flush_page_vld(flush_page_vld), .flush_page_addr(flush_page_addr),
        .flush_pid_vld(flush_pid_vld), .flush_pid(flush_pid)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(string req);
        chk(req, "acc_q", acc_q, e_acc);
        chk(req, "misc_q", misc_q, e_misc);
        chk(req, "pta_q", pta_q, e_pta);
        chk(req, "flush_page_vld", {31'd0, flush_page_vld}, {31'd0, e_fpv});
        if (e_fpv) chk(req, "flush_page_addr", flush_page_addr, e_fpa);
        chk(req, "flush_pid_vld", {31'd0, flush_pid_vld}, {31'd0, e_fidv});
        if (e_fidv) chk(req, "flush_pid", {24'd0, flush_pid}, {24'd0, e_fid});
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_vpn[i] = '0; m_g[i] = 1'b0; m_v[i] = 1'b0; m_pid[i] = '0; m_dat[i] = '0;
        end
        e_acc = '0; e_misc = '0; e_pta = '0; e_fpa = '0;
        e_fpv = 1'b0; e_fidv = 1'b0; e_fid = '0; vpn_sh = '0; pid_sh = '0;
    endtask

    // drive one cycle at the falling edge, predict, then compare at the next falling edge
    task automatic step(logic en, logic [1:0] sel, logic [31:0] d, string req);
        int way, idx;
        logic nvalid;
        logic [7:0] np;
        wr_en = en; wr_sel = sel; wr_data = d;
        e_fpv = 1'b0; e_fidv = 1'b0;
        if (en) begin
            case (sel)
                2'd0: if (e_misc[1]) begin
                    way = int'((e_misc >> 24) & 32'h3);
                    idx = way * EPW + int'(vpn_sh % EPW);
                    nvalid = (vpn_sh < 20'hC0000);
                    if (m_vpn[idx] != vpn_sh || m_g[idx] != d[24] || m_v[idx] != nvalid ||
                        m_pid[idx] != pid_sh || m_dat[idx] != d[23:0]) begin
                        if (m_v[idx]) begin
                            e_fpv = 1'b1;
                            e_fpa = {m_vpn[idx], 12'h000};
                        end
                        m_vpn[idx] = vpn_sh; m_g[idx] = d[24]; m_v[idx] = nvalid;
                        m_pid[idx] = pid_sh; m_dat[idx] = d[23:0];
                    end
                    e_misc[25:24] = 2'((way + 1) % WAYS);
                end
                2'd1: begin
                    np = d[11:4];
                    if (np != pid_sh) begin
                        e_fidv = 1'b1;
                        e_fid  = pid_sh;
                    end
                    pid_sh = np;
                    if (d[0]) begin
                        way = int'((d >> 24) & 32'h3);
                        idx = way * EPW + int'(vpn_sh % EPW);
                        e_acc = (e_acc & 32'hFE00_0000) | ({31'd0, m_g[idx]} << 24) | {8'd0, m_dat[idx]};
                        e_misc = (d & ~32'h0000_0FF0) | ({24'd0, m_pid[idx]} << 4);
                        e_pta = (e_pta & ~32'h003F_FFFC) | ({12'd0, m_vpn[idx]} << 2);
                    end else begin
                        e_misc = d;
                    end
                end
                2'd2: begin
                    e_pta  = (d & ~32'h003F_FFFC) | (e_pta & 32'h003F_FFFC);
                    vpn_sh = d[21:2];
                end
                default: begin
                end
            endcase
        end
        @(negedge clk);
        compare_all(req);
    endtask

    localparam logic [1:0] ACC = 2'd0, MISC = 2'd1, PTA = 2'd2, NONE = 2'd3;

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare_all("R1");
        step(1, MISC, 32'h0000_0001, "R1");                 // read entry 0 after reset
        step(0, ACC, 32'h0, "R1");
        // page-table write: base and low bits change, VPN field held
        step(1, PTA, 32'hABC0_0000 | (32'd5 << 2) | 32'd1, "R7");
        step(1, PTA, 32'h1240_0000 | (32'd5 << 2), "R7");
        // enable stores, identifier 0x12 (flush of identifier 0)
        step(1, MISC, 32'h0000_0122, "R9");
        // stores into ways 0..3 of set 5
        step(1, ACC, 32'hFE00_0000 | (32'd1 << 24) | (32'd1 << 23) | 32'h01234, "R2");
        step(1, ACC, 32'h00E0_0000 | 32'h0AAAA, "R4");
        step(1, ACC, 32'h0010_0000 | 32'h05555, "R5");
        step(1, ACC, 32'h0000_0000 | 32'h0F0F0, "R5");     // way wraps to 0
        // same contents into way 0: no flush
        step(1, ACC, 32'hFE00_0000 | (32'd1 << 24) | (32'd1 << 23) | 32'h01234, "R10");
        // different contents into valid way 1: page flush
        step(1, ACC, 32'h0040_0000 | 32'h00001, "R10");
        // back-to-back replacement, way 2 then way 3
        step(1, ACC, 32'h0080_0000 | 32'h00002, "R10");
        step(1, ACC, 32'h0080_0000 | 32'h00003, "R10");
        // read way 1 back
        step(1, MISC, 32'h0100_0121, "R6");
        // read way 0: global flag returns at bit 24
        step(1, MISC, 32'h0000_0121, "R4");
        // writes with write enable clear store nothing
        step(1, ACC, 32'h00FF_FFFF, "R11");
        step(1, NONE, 32'hFFFF_FFFF, "R11");
        step(0, MISC, 32'hFFFF_FFFF, "R11");
        step(1, MISC, 32'h0000_0121, "R11");
        step(1, MISC, 32'h0100_0121, "R11");
        // VPN at the invalid limit: stored invalid, no flush on overwrite
        step(1, PTA, 32'h0000_0000 | (32'hC0001 << 2), "R3");
        step(1, MISC, 32'h0200_0122, "R3");
        step(1, ACC, 32'h0000_0777, "R3");
        step(1, MISC, 32'h0200_0122, "R3");
        step(1, ACC, 32'h0000_0888, "R3");
        step(1, MISC, 32'h0200_0121, "R3");
        // VPN just below limit: valid, replacement flushes
        step(1, PTA, 32'h0000_0000 | (32'hBFFFF << 2), "R3");
        step(1, MISC, 32'h0300_0122, "R2");
        step(1, ACC, 32'h0000_0111, "R2");
        step(1, MISC, 32'h0300_0122, "R3");
        step(1, ACC, 32'h0000_0222, "R3");
        // identifier change together with a read in the same write
        step(1, MISC, 32'h0300_0561, "R9");
        step(1, MISC, 32'h0300_0561, "R9");
        step(1, MISC, 32'h0000_0AB0, "R9");
        // new identifier is used in the next stored tag
        step(1, MISC, 32'h0000_0AB2, "R2");
        step(1, ACC, 32'h0000_0333, "R2");
        step(1, MISC, 32'h0000_0AB1, "R6");
        step(0, ACC, 32'h0, "R8");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule